// File: doc/BRIEF.md
# Polled Mailbox Command Requester

This block runs one command/response exchange with a remote service controller through a bank of shared 64-bit mailbox registers. A client hands it up to four request words, one mask that says which request words to send and another that says which reply words to fetch, a choice between a short and a long reply deadline, and a start strobe. The block then works alone as master of a simple register read/write port. It gives the request a fresh sequence number and confirms that the remote side has no message pending. It writes the selected words, sets the remote doorbell and polls the local doorbell at a fixed spacing until a reply shows up or the deadline passes. It then reads the selected reply words, clears the reply flag and checks the reply header.

When it finishes, the block pulses `done` once and gives one of four result codes. The reply words stay on `rsp_words` until the next exchange begins. Each register offset is added to the parameter `BASE_ADDR`. The poll spacing and both deadlines are parameters counted in clock cycles.

Top module: `mbox_requester`

## Requirements
- R1: Only one exchange runs at a time. `busy` is high from the cycle after an accepted start until `done`. A start that arrives while `busy` is high is ignored: it causes no extra bus traffic and does not advance the sequence number.
- R2: A 16-bit sequence number is incremented once for each accepted start, so the first exchange after reset uses 1. The value is placed in bits [31:16] of request word 0. Every other bit of that word is sent as supplied.
- R3: The first bus operation of each exchange reads the remote doorbell at BASE_ADDR+0x60. If bit 63 of that read is set, the exchange ends with result code 1 and performs no write.
- R4: Request word i is written to BASE_ADDR+0x50+i, in ascending order of i, only when bit i of `req_mask` is set.
- R5: After the last request word, the block writes 0x8000_0000_0000_0000 to BASE_ADDR+0x62, the set-bits alias of the remote doorbell.
- R6: The block reads the local doorbell at BASE_ADDR+0x63 until bit 63 is set. Between two reads it waits at least POLL_CYC cycles with no bus request.
- R7: A wait counter advances during the gaps between polls. When a poll read returns bit 63 clear and the count exceeds SHORT_LIM (or LONG_LIM when `long_wait` was high at start), the exchange ends with result code 2. It then reads no reply word and makes no acknowledge write. That read is poll number floor(LIMIT/POLL_CYC)+2, and a reply seen on that same read still counts as success.
- R8: Reply word i is read from BASE_ADDR+0x54+i, in ascending order, only when bit i of `rsp_mask` is set. It is shown on `rsp_words[i]`.
- R9: After the reply reads, the block writes 0x7FFF_FFFF_FFFF_FFFF to BASE_ADDR+0x64, the clear-bits alias of the local doorbell. This write completes before `done`.
- R10: After the acknowledge write, reply word 0 is checked. If bits [63:48] or [47:32] are non-zero, or bits [31:16] differ from the sequence number that was sent, the result code is 3. Otherwise it is 0.
- R11: On each accepted start, `rsp_words[0]` is preset to all ones and the other reply words to zero. A word that is not read keeps its preset value. A preset word 0 therefore fails the R10 check.
- R12: `done` is high for exactly one cycle per exchange, and `err` holds its code until the next `done`. `bus_req`, `bus_addr`, `bus_we` and `bus_wdata` stay constant until `bus_ack`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Start strobe, taken only while idle |
| req_words | input | NW*64 | Request words, word i at [i] |
| req_mask | input | NW | Request words to send |
| rsp_mask | input | NW | Reply words to read |
| long_wait | input | 1 | Use the long reply deadline |
| busy | output | 1 | Exchange in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 2 | 0 ok, 1 remote not ready, 2 timeout, 3 bad reply |
| rsp_words | output | NW*64 | Reply words |
| bus_req | output | 1 | Register access request |
| bus_we | output | 1 | Access is a write |
| bus_addr | output | ADDR_W | Register address |
| bus_wdata | output | 64 | Write data |
| bus_ack | input | 1 | Access complete |
| bus_rdata | input | 64 | Read data, valid with `bus_ack` |

## Verification
The bench sweeps every request mask and every reply mask. A design that used the mask bit as a packed index, instead of letting the address advance across skipped words, would write to the wrong mailbox slot. The deadline is tested on both sides, for both ranges: a reply on the final allowed poll must succeed and one poll later must time out, which exposes a `>=` compare or a check done in the wrong order. Bad primary status, bad secondary status, an echoed sequence number off by one and an unread word 0 must each give code 3. A remote doorbell that is already busy must leave the write log empty, and a start issued mid-exchange must not cost a sequence number.

// File: rtl/mbox_pkg.sv
package mbox_pkg;
   localparam int unsigned WORD_W = 64;
   typedef logic [WORD_W-1:0] word_t;

   typedef enum logic [1:0] {
      ERR_OK          = 2'd0,
      ERR_REMOTE_BUSY = 2'd1,
      ERR_TIMEOUT     = 2'd2,
      ERR_BAD_REPLY   = 2'd3
   } err_e;

   typedef enum logic [3:0] {
      S_IDLE, S_PROBE, S_REQ, S_RING, S_POLL, S_GAP, S_RSP, S_ACK, S_CHECK
   } state_e;

   localparam logic [11:0] OFS_REQ     = 12'h050;
   localparam logic [11:0] OFS_RSP     = 12'h054;
   localparam logic [11:0] OFS_RDB     = 12'h060;
   localparam logic [11:0] OFS_RDB_SET = 12'h062;
   localparam logic [11:0] OFS_LDB     = 12'h063;
   localparam logic [11:0] OFS_LDB_CLR = 12'h064;

   localparam word_t RING_VAL  = 64'h8000_0000_0000_0000;
   localparam word_t CLEAR_VAL = 64'h7FFF_FFFF_FFFF_FFFF;
   localparam word_t PRESET_W0 = '1;
endpackage

// File: rtl/mbox_req_stamp.sv
module mbox_req_stamp
   import mbox_pkg::*;
#(
   parameter int unsigned NW = 4
) (
   input  logic [NW-1:0][WORD_W-1:0] raw,
   input  logic [15:0]               seq,
   output logic [NW-1:0][WORD_W-1:0] stamped
);
   for (genvar i = 0; i < NW; i++) begin : g_word
      if (i == 0) begin : g_hdr
         assign stamped[i] = {raw[i][63:32], seq, raw[i][15:0]};
      end else begin : g_pass
         assign stamped[i] = raw[i];
      end
   end
endmodule

// File: rtl/mbox_poll_timer.sv
module mbox_poll_timer #(
   parameter int unsigned      POLL_CYC  = 1250,
   parameter longint unsigned  SHORT_LIM = 64'd12_500_000,
   parameter longint unsigned  LONG_LIM  = 64'd3_750_000_000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clear,
   input  logic long_sel,
   input  logic wait_en,
   output logic wait_done,
   output logic expired
);
   localparam int EL_W = $clog2(LONG_LIM + 64'(POLL_CYC)) + 1;

   if (POLL_CYC < 1) begin : g_bad_poll
      $error("mbox_poll_timer: POLL_CYC must be at least 1");
   end
   if (LONG_LIM < SHORT_LIM) begin : g_bad_lim
      $error("mbox_poll_timer: LONG_LIM must not be below SHORT_LIM");
   end

   logic [EL_W-1:0] elapsed_q;

   always_ff @(posedge clk) begin
      if (!rst_n)       elapsed_q <= '0;
      else if (clear)   elapsed_q <= '0;
      else if (wait_en) elapsed_q <= elapsed_q + 1'b1;
   end

   if (POLL_CYC == 1) begin : g_single
      assign wait_done = wait_en;
   end else begin : g_count
      localparam int IV_W = $clog2(POLL_CYC);
      logic [IV_W-1:0] iv_q;
      always_ff @(posedge clk) begin
         if (!rst_n || !wait_en)              iv_q <= '0;
         else if (iv_q == IV_W'(POLL_CYC - 1)) iv_q <= '0;
         else                                  iv_q <= iv_q + 1'b1;
      end
      assign wait_done = wait_en && (iv_q == IV_W'(POLL_CYC - 1));
   end

   assign expired = elapsed_q > (long_sel ? EL_W'(LONG_LIM) : EL_W'(SHORT_LIM));
endmodule

// File: rtl/mbox_rsp_check.sv
module mbox_rsp_check
   import mbox_pkg::*;
(
   input  logic [63:16] hdr,
   input  logic [15:0]  seq_sent,
   output err_e         verdict
);
   logic status_bad;
   logic seq_bad;
   assign status_bad = (hdr[63:48] != 16'h0) || (hdr[47:32] != 16'h0);
   assign seq_bad    = hdr[31:16] != seq_sent;
   assign verdict    = (status_bad || seq_bad) ? ERR_BAD_REPLY : ERR_OK;
endmodule

// File: rtl/mbox_requester.sv
module mbox_requester
   import mbox_pkg::*;
#(
   parameter int unsigned               ADDR_W    = 32,
   parameter logic [ADDR_W-1:0]         BASE_ADDR = '0,
   parameter int unsigned               NW        = 4,
   parameter int unsigned               POLL_CYC  = 1250,
   parameter longint unsigned           SHORT_LIM = 64'd12_500_000,
   parameter longint unsigned           LONG_LIM  = 64'd3_750_000_000
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      start,
   input  logic [NW-1:0][WORD_W-1:0] req_words,
   input  logic [NW-1:0]             req_mask,
   input  logic [NW-1:0]             rsp_mask,
   input  logic                      long_wait,
   output logic                      busy,
   output logic                      done,
   output logic [1:0]                err,
   output logic [NW-1:0][WORD_W-1:0] rsp_words,
   output logic                      bus_req,
   output logic                      bus_we,
   output logic [ADDR_W-1:0]         bus_addr,
   output logic [WORD_W-1:0]         bus_wdata,
   input  logic                      bus_ack,
   input  logic [WORD_W-1:0]         bus_rdata
);
   localparam int IDX_W = (NW > 1) ? $clog2(NW) : 1;
   localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NW - 1);

   if (NW < 1 || NW > 4) begin : g_bad_nw
      $error("mbox_requester: NW must be 1 to 4");
   end
   if (ADDR_W < 12) begin : g_bad_aw
      $error("mbox_requester: ADDR_W must be at least 12");
   end

   state_e                    state_q;
   logic [IDX_W-1:0]          idx_q;
   logic [15:0]               seq_q;
   logic [NW-1:0][WORD_W-1:0] req_q;
   logic [NW-1:0][WORD_W-1:0] stamped;
   logic [NW-1:0]             qmask_q;
   logic [NW-1:0]             rmask_q;
   logic                      long_q;
   logic [NW-1:0][WORD_W-1:0] rsp_q;
   err_e                      err_q;
   logic                      done_q;
   err_e                      verdict;
   logic                      wait_done;
   logic                      expired;
   logic                      last_idx;

   assign last_idx = (idx_q == LAST_IDX);

   mbox_req_stamp #(.NW(NW)) u_stamp (
      .raw     (req_q),
      .seq     (seq_q),
      .stamped (stamped)
   );

   mbox_poll_timer #(
      .POLL_CYC  (POLL_CYC),
      .SHORT_LIM (SHORT_LIM),
      .LONG_LIM  (LONG_LIM)
   ) u_timer (
      .clk       (clk),
      .rst_n     (rst_n),
      .clear     (state_q == S_IDLE),
      .long_sel  (long_q),
      .wait_en   (state_q == S_GAP),
      .wait_done (wait_done),
      .expired   (expired)
   );

   mbox_rsp_check u_check (
      .hdr      (rsp_q[0][63:16]),
      .seq_sent (seq_q),
      .verdict  (verdict)
   );

   always_comb begin
      bus_req   = 1'b0;
      bus_we    = 1'b0;
      bus_addr  = BASE_ADDR;
      bus_wdata = '0;
      unique case (state_q)
         S_PROBE: begin
            bus_req  = 1'b1;
            bus_addr = BASE_ADDR + ADDR_W'(OFS_RDB);
         end
         S_REQ: begin
            bus_req   = qmask_q[idx_q];
            bus_we    = 1'b1;
            bus_addr  = BASE_ADDR + ADDR_W'(OFS_REQ) + ADDR_W'(idx_q);
            bus_wdata = stamped[idx_q];
         end
         S_RING: begin
            bus_req   = 1'b1;
            bus_we    = 1'b1;
            bus_addr  = BASE_ADDR + ADDR_W'(OFS_RDB_SET);
            bus_wdata = RING_VAL;
         end
         S_POLL: begin
            bus_req  = 1'b1;
            bus_addr = BASE_ADDR + ADDR_W'(OFS_LDB);
         end
         S_RSP: begin
            bus_req  = rmask_q[idx_q];
            bus_addr = BASE_ADDR + ADDR_W'(OFS_RSP) + ADDR_W'(idx_q);
         end
         S_ACK: begin
            bus_req   = 1'b1;
            bus_we    = 1'b1;
            bus_addr  = BASE_ADDR + ADDR_W'(OFS_LDB_CLR);
            bus_wdata = CLEAR_VAL;
         end
         default: ;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= S_IDLE;
         idx_q   <= '0;
         seq_q   <= '0;
         req_q   <= '0;
         qmask_q <= '0;
         rmask_q <= '0;
         long_q  <= 1'b0;
         rsp_q   <= '0;
         rsp_q[0] <= PRESET_W0;
         err_q   <= ERR_OK;
         done_q  <= 1'b0;
      end else begin
         done_q <= 1'b0;
         unique case (state_q)
            S_IDLE: begin
               if (start) begin
                  seq_q    <= seq_q + 16'd1;
                  req_q    <= req_words;
                  qmask_q  <= req_mask;
                  rmask_q  <= rsp_mask;
                  long_q   <= long_wait;
                  rsp_q    <= '0;
                  rsp_q[0] <= PRESET_W0;
                  idx_q    <= '0;
                  state_q  <= S_PROBE;
               end
            end
            S_PROBE: begin
               if (bus_ack) begin
                  if (bus_rdata[63]) begin
                     err_q   <= ERR_REMOTE_BUSY;
                     done_q  <= 1'b1;
                     state_q <= S_IDLE;
                  end else begin
                     idx_q   <= '0;
                     state_q <= S_REQ;
                  end
               end
            end
            S_REQ: begin
               if (!qmask_q[idx_q] || bus_ack) begin
                  if (last_idx) state_q <= S_RING;
                  else          idx_q   <= idx_q + 1'b1;
               end
            end
            S_RING: begin
               if (bus_ack) state_q <= S_POLL;
            end
            S_POLL: begin
               if (bus_ack) begin
                  if (bus_rdata[63]) begin
                     idx_q   <= '0;
                     state_q <= S_RSP;
                  end else if (expired) begin
                     err_q   <= ERR_TIMEOUT;
                     done_q  <= 1'b1;
                     state_q <= S_IDLE;
                  end else begin
                     state_q <= S_GAP;
                  end
               end
            end
            S_GAP: begin
               if (wait_done) state_q <= S_POLL;
            end
            S_RSP: begin
               if (!rmask_q[idx_q] || bus_ack) begin
                  if (rmask_q[idx_q]) rsp_q[idx_q] <= bus_rdata;
                  if (last_idx) state_q <= S_ACK;
                  else          idx_q   <= idx_q + 1'b1;
               end
            end
            S_ACK: begin
               if (bus_ack) state_q <= S_CHECK;
            end
            S_CHECK: begin
               err_q   <= verdict;
               done_q  <= 1'b1;
               state_q <= S_IDLE;
            end
            default: state_q <= S_IDLE;
         endcase
      end
   end

   assign busy      = (state_q != S_IDLE);
   assign done      = done_q;
   assign err       = err_q;
   assign rsp_words = rsp_q;
endmodule

// File: rtl/mbox_requester_chk.sv
module mbox_requester_chk
   import mbox_pkg::*;
#(
   parameter int unsigned       ADDR_W    = 32,
   parameter logic [ADDR_W-1:0] BASE_ADDR = '0
) (
   input logic              clk,
   input logic              rst_n,
   input logic              start,
   input logic              busy,
   input logic              done,
   input logic [1:0]        err,
   input logic              bus_req,
   input logic              bus_we,
   input logic [ADDR_W-1:0] bus_addr,
   input logic [WORD_W-1:0] bus_wdata,
   input logic              bus_ack,
   input logic [15:0]       seq_q
);
   logic wrote_q;
   always_ff @(posedge clk) begin
      if (!rst_n)                          wrote_q <= 1'b0;
      else if (!busy && start)             wrote_q <= 1'b0;
      else if (bus_req && bus_we && bus_ack) wrote_q <= 1'b1;
   end

   AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      bus_req && !bus_ack |=> bus_req && $stable(bus_addr) && $stable(bus_we) && $stable(bus_wdata)); // R12
   AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done); // R12
   AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> !bus_req); // R1
   AST_SEQ_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> seq_q == $past(seq_q) + 16'd1); // R2
   AST_SEQ_STAMP: assert property (@(posedge clk) disable iff (!rst_n)
      bus_req && bus_we && bus_addr == BASE_ADDR + ADDR_W'(OFS_REQ) |-> bus_wdata[31:16] == seq_q); // R2
   AST_RING_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
      bus_req && bus_we && bus_addr == BASE_ADDR + ADDR_W'(OFS_RDB_SET) |-> bus_wdata == RING_VAL); // R5
   AST_CLEAR_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
      bus_req && bus_we && bus_addr == BASE_ADDR + ADDR_W'(OFS_LDB_CLR) |-> bus_wdata == CLEAR_VAL); // R9
   AST_NOT_READY_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
      done && err == 2'd1 |-> !wrote_q); // R3
endmodule

bind mbox_requester mbox_requester_chk #(.ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .start     (start),
   .busy      (busy),
   .done      (done),
   .err       (err),
   .bus_req   (bus_req),
   .bus_we    (bus_we),
   .bus_addr  (bus_addr),
   .bus_wdata (bus_wdata),
   .bus_ack   (bus_ack),
   .seq_q     (seq_q)
);

// File: tb/sim_mbox_requester.sv
`timescale 1ns/1ps
module sim_mbox_requester;
   localparam int          AW    = 32;
   localparam logic [31:0] BASE  = 32'h0000_1000;
   localparam int          POLL  = 4;
   localparam int          SLIM  = 20;
   localparam int          LLIM  = 60;
   localparam logic [63:0] ONES  = 64'hFFFF_FFFF_FFFF_FFFF;
   localparam logic [63:0] RINGV = 64'h8000_0000_0000_0000;
   localparam logic [63:0] CLRV  = 64'h7FFF_FFFF_FFFF_FFFF;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic start = 1'b0;
   logic [3:0][63:0] req_words = '0;
   logic [3:0] req_mask = '0;
   logic [3:0] rsp_mask = '0;
   logic long_wait = 1'b0;
   logic busy, done;
   logic [1:0] err;
   logic [3:0][63:0] rsp_words;
   logic bus_req, bus_we, bus_ack;
   logic [AW-1:0] bus_addr;
   logic [63:0] bus_wdata, bus_rdata;

   always #4 clk = ~clk;

   mbox_requester #(
      .ADDR_W(AW), .BASE_ADDR(BASE), .NW(4),
      .POLL_CYC(POLL), .SHORT_LIM(SLIM), .LONG_LIM(LLIM)
   ) u0 (
      .clk(clk), .rst_n(rst_n), .start(start), .req_words(req_words),
      .req_mask(req_mask), .rsp_mask(rsp_mask), .long_wait(long_wait),
      .busy(busy), .done(done), .err(err), .rsp_words(rsp_words),
      .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_ack(bus_ack), .bus_rdata(bus_rdata)
   );

   // remote register model
   logic        cfg_clr = 1'b0;
   logic [63:0] cfg_rdb = '0;
   logic [63:0] cfg_rsp [0:3];
   int          ready_at = 1;
   logic [63:0] rdb_q, ldb_q;
   logic [63:0] mbox [0:7];
   logic [63:0] wr_data [0:15];
   logic [31:0] wr_ofs [0:15];
   int          wr_n, poll_n, cyc;
   int          poll_at [0:31];
   logic        ack_q = 1'b0;
   logic [63:0] rdata_q = '0;
   wire  [31:0] ofs = bus_addr - BASE;

   assign bus_ack   = ack_q;
   assign bus_rdata = rdata_q;

   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (cfg_clr) begin
         rdb_q  <= cfg_rdb;
         ldb_q  <= '0;
         wr_n   <= 0;
         poll_n <= 0;
         ack_q  <= 1'b0;
         for (int i = 0; i < 4; i++) mbox[4+i] <= cfg_rsp[i];
      end else if (bus_req && !ack_q) begin
         ack_q <= 1'b1;
         if (bus_we) begin
            if (wr_n < 16) begin
               wr_ofs[wr_n]  <= ofs;
               wr_data[wr_n] <= bus_wdata;
            end
            wr_n <= wr_n + 1;
            if (ofs >= 32'h50 && ofs <= 32'h53) mbox[ofs-32'h50] <= bus_wdata;
            else if (ofs == 32'h62) rdb_q <= rdb_q | bus_wdata;
            else if (ofs == 32'h64) ldb_q <= ldb_q & bus_wdata;
         end else begin
            if (ofs == 32'h60) rdata_q <= rdb_q;
            else if (ofs == 32'h63) begin
               if (poll_n < 32) poll_at[poll_n] <= cyc;
               poll_n <= poll_n + 1;
               if (poll_n + 1 >= ready_at) begin
                  ldb_q   <= ldb_q | RINGV;
                  rdata_q <= ldb_q | RINGV;
               end else rdata_q <= ldb_q;
            end else if (ofs >= 32'h54 && ofs <= 32'h57) rdata_q <= mbox[ofs-32'h50];
            else rdata_q <= '0;
         end
      end else ack_q <= 1'b0;
   end

   int n_chk = 0;
   int n_err = 0;
   logic [15:0] exp_seq = '0;

   task automatic check(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   task automatic exchange(input string tag, input logic [3:0] qm, input logic [3:0] rm,
                           input bit lng, input int rdy, input bit rbusy,
                           input logic [31:0] status, input bit seq_off, input int extra_at);
      logic [63:0] w [0:3];
      logic [63:0] r [0:3];
      logic [63:0] ew [0:15];
      logic [31:0] ea [0:15];
      int  en, maxr, ecode, waited, exp_polls;
      bit  got;
      exp_seq = exp_seq + 16'd1;
      for (int i = 0; i < 4; i++) w[i] = 64'h0000_0A00_0000_0000 + (64'(i) << 40) + {32'h0, 16'h5A5A, 8'hD1, 8'(i+1)};
      r[0] = {status, (seq_off ? exp_seq + 16'd1 : exp_seq), 16'hD101};
      for (int i = 1; i < 4; i++) r[i] = 64'hC0DE_0000_0000_0000 + (64'(exp_seq) << 8) + 64'(i);
      @(negedge clk);
      cfg_clr  = 1'b1;
      cfg_rdb  = rbusy ? RINGV : 64'h0;
      ready_at = rdy;
      for (int i = 0; i < 4; i++) cfg_rsp[i] = r[i];
      @(negedge clk);
      cfg_clr = 1'b0;
      for (int i = 0; i < 4; i++) req_words[i] = w[i];
      req_mask = qm; rsp_mask = rm; long_wait = lng;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      check("R1", {tag, " busy after start"}, 64'(busy), 64'd1);
      got = 1'b0; waited = 0;
      while (!got && waited < 2000) begin
         if (extra_at != 0 && waited == extra_at) begin
            req_mask = 4'hF; start = 1'b1;
         end else start = 1'b0;
         @(negedge clk);
         waited++;
         if (done) got = 1'b1;
      end
      start = 1'b0;
      if (!got) begin
         check("R12", {tag, " watchdog on done"}, 64'd0, 64'd1);
         return;
      end
      maxr = (lng ? LLIM : SLIM) / POLL + 2;
      if (rbusy) ecode = 1;
      else if (rdy > maxr) ecode = 2;
      else if (!rm[0] || status != 32'h0 || seq_off) ecode = 3;
      else ecode = 0;
      check(ecode == 1 ? "R3" : ecode == 2 ? "R7" : "R10", {tag, " result code"}, 64'(err), 64'(ecode));
      check("R1", {tag, " idle at done"}, 64'(busy), 64'd0);
      en = 0;
      if (!rbusy) begin
         for (int i = 0; i < 4; i++) if (qm[i]) begin
            ea[en] = 32'h50 + i;
            ew[en] = (i == 0) ? {w[0][63:32], exp_seq, w[0][15:0]} : w[i];
            en++;
         end
         ea[en] = 32'h62; ew[en] = RINGV; en++;
         if (ecode != 2) begin ea[en] = 32'h64; ew[en] = CLRV; en++; end
      end
      check("R4", {tag, " write count"}, 64'(wr_n), 64'(en));
      if (wr_n == en)
         for (int k = 0; k < en; k++) begin
            check(ea[k] == 32'h62 ? "R5" : ea[k] == 32'h64 ? "R9" : (ea[k] == 32'h50 ? "R2" : "R4"),
                  {tag, " write address"}, 64'(wr_ofs[k]), 64'(ea[k]));
            check(ea[k] == 32'h62 ? "R5" : ea[k] == 32'h64 ? "R9" : (ea[k] == 32'h50 ? "R2" : "R4"),
                  {tag, " write data"}, wr_data[k], ew[k]);
         end
      exp_polls = rbusy ? 0 : (ecode == 2 ? maxr : rdy);
      check("R7", {tag, " poll reads"}, 64'(poll_n), 64'(exp_polls));
      for (int k = 1; k < poll_n && k < 32; k++)
         check("R6", {tag, " poll spacing"}, 64'(poll_at[k] - poll_at[k-1] >= POLL + 1), 64'd1);
      if (ecode == 0 || ecode == 3)
         check("R9", {tag, " reply flag cleared"}, 64'(ldb_q[63]), 64'd0);
      for (int i = 0; i < 4; i++) begin
         logic [63:0] er;
         er = (i == 0) ? ONES : 64'h0;
         if ((ecode == 0 || ecode == 3) && rm[i]) er = r[i];
         check(rm[i] && ecode != 1 && ecode != 2 ? "R8" : "R11", {tag, " reply word"}, rsp_words[i], er);
      end
      @(negedge clk);
      check("R12", {tag, " done pulse width"}, 64'(done), 64'd0);
      check("R12", {tag, " err held"}, 64'(err), 64'(ecode));
      check("R1", {tag, " no restart from stray start"}, 64'(busy), 64'd0);
   endtask

   initial begin
      #(200000 * 8);
      n_chk++; n_err++;
      $display("FAIL R12 global watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
   end

   initial begin
      for (int i = 0; i < 4; i++) cfg_rsp[i] = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1", "reset busy", 64'(busy), 64'd0);
      check("R12", "reset done", 64'(done), 64'd0);
      check("R12", "reset bus_req", 64'(bus_req), 64'd0);
      check("R11", "reset reply word 0", rsp_words[0], ONES);

      exchange("basic", 4'hF, 4'hF, 1'b0, 3, 1'b0, 32'h0, 1'b0, 0);
      for (int m = 0; m < 16; m++)
         exchange("req mask sweep", 4'(m), 4'h1, 1'b0, 1, 1'b0, 32'h0, 1'b0, 0);
      for (int m = 0; m < 16; m++)
         exchange("rsp mask sweep", 4'h1, 4'(m), 1'b0, 2, 1'b0, 32'h0, 1'b0, 0);
      exchange("remote busy", 4'hF, 4'hF, 1'b0, 1, 1'b1, 32'h0, 1'b0, 0);
      exchange("short last poll", 4'h3, 4'hF, 1'b0, 7, 1'b0, 32'h0, 1'b0, 0);
      exchange("short timeout", 4'h3, 4'hF, 1'b0, 8, 1'b0, 32'h0, 1'b0, 0);
      exchange("after timeout", 4'h1, 4'h2, 1'b0, 1, 1'b0, 32'h0, 1'b0, 0);
      exchange("long last poll", 4'h1, 4'h1, 1'b1, 17, 1'b0, 32'h0, 1'b0, 0);
      exchange("long timeout", 4'h1, 4'h1, 1'b1, 18, 1'b0, 32'h0, 1'b0, 0);
      exchange("primary bad", 4'h1, 4'h1, 1'b0, 1, 1'b0, 32'h0001_0000, 1'b0, 0);
      exchange("secondary bad", 4'h1, 4'h1, 1'b0, 1, 1'b0, 32'h0000_0010, 1'b0, 0);
      exchange("seq echo off", 4'h1, 4'h1, 1'b0, 1, 1'b0, 32'h0, 1'b1, 0);
      exchange("start while busy", 4'h5, 4'h3, 1'b0, 4, 1'b0, 32'h0, 1'b0, 6);
      exchange("seq after ignored start", 4'h1, 4'h1, 1'b0, 1, 1'b0, 32'h0, 1'b0, 0);

      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
   end
endmodule